// File: doc/BRIEF.md
# Register State Handover Controller

This block moves the contents of a live, clock-enabled register into a replica register while the surrounding circuit keeps running. It owns the replica register and the 2:1 multiplexer in front of it. The original register stays outside the block: the block sees the original's current output, its next-state value and its clock enable. A slow controller in another clock domain steps the handover through a fixed sequence of commands. Each command is a 4-bit code held stable on `cmd_code_i` while a request level on `cmd_req_i` rises.

While the aid path is in bypass, the replica input multiplexer is steered by the circuit's own clock enable. With the enable low, a capture command copies the original's present output into the replica. With the enable high, the replica takes the same next-state value that the original takes on that edge. An update that lands in the middle of the copy therefore cannot leave the two registers disagreeing.

The final steps work as follows:
- After the output-merge step, both outputs are paralleled.
- The retire step hands the block's output over to the replica.
- A free-running mode skips the bypass and capture steps, because a replica whose enable is always on acquires the state by itself.
- A latch build treats a 1-to-0 transition of the enable input as the storage event.

Top module: `ffx_handover`

## Requirements
- R1: While reset is asserted and until the first accepted configure command, the stage output is 15 (idle). Retire, bypass, capture and the error flag are 0, and the replica output holds 0 whatever the enable and data inputs do.
- R2: A command is taken once per rising edge of the request level, after a two-flop synchronizer. The stage output changes on the third clock edge after the request rises and never in a cycle without a taken command.
- R3: In gated mode the only legal order of codes is configure 0, bypass-on 1, capture-on 2, capture-off 3, bypass-off 4, enable-merge 5, aid-detach 6, output-merge 7 and retire 8. The stage output shows the last accepted code.
- R4: When the free-run input is 1 at an accepted configure command, the legal order is 0, 5, 7, 8. Codes 1, 2, 3, 4 and 6 are then rejected.
- R5: A command that is not the next legal one leaves the stage unchanged and sets the error flag. The flag stays set until a configure command is accepted, which clears it.
- R6: The bypass output is 1 at stages 1, 2 and 3 in gated mode only. The capture output is 1 at stage 2 in gated mode only.
- R7: In the cycle where capture is on and the effective enable is low, the replica loads the original's output. From then on it equals the original register on every cycle.
- R8: While bypass is on and the effective enable is high, the replica loads the next-state value on the same edge as the original.
- R9: From the accepted configure command onward and outside capture, the replica loads the next-state value whenever the effective enable is high. In free-run mode that is every cycle.
- R10: The block output equals the original's output until retire is accepted. From stage 8 on, retire is 1 and the block output equals the replica.
- R11: Retire is accepted only from the output-merge stage, so original and replica are paralleled for at least one clock cycle before retirement.
- R12: With LATCH_MODE=1 the effective enable is high only in a cycle where the enable input is 0 and was 1 in the previous cycle. The same sequence then keeps the replica equal to a latch holding the data present at that falling transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_req_i | input | 1 | Asynchronous command request level; a rising edge issues one command |
| cmd_code_i | input | 4 | Command code, stable while the request is high |
| free_run_i | input | 1 | Mode selected at configure: 1 = enable always active |
| orig_q_i | input | W | Current output of the original register |
| nxt_d_i | input | W | Next-state value feeding both registers |
| orig_en_i | input | 1 | Circuit clock enable (latch gate when LATCH_MODE=1) |
| rep_q_o | output | W | Replica register output |
| out_q_o | output | W | Merged output: original before retire, replica after |
| retire_o | output | 1 | Original register retired |
| stage_o | output | 4 | Last accepted step code, 15 when idle |
| bypass_o | output | 1 | Aid path in bypass |
| capture_o | output | 1 | Capture enable of the replica active |
| seq_err_o | output | 1 | Sticky out-of-order command flag |

## Verification
The request is raised on a falling clock edge. The stage is then sampled on the second falling edge after that, where it must still be unchanged, and on the third, where it must show the new code. These are exactly the two synchronizer flops plus the stage register. Bypass, capture and error outputs are sampled a few cycles after a stage settles, because each is a direct decode of the stage register. The replica is compared with a bench model of the original register on every falling edge from one full cycle after capture was enabled. That is the first edge at which the copy or a shared next-state load has landed. After retire, the original input is inverted, so the block output can only match the model through the replica.

// File: rtl/ffx_pkg.sv
package ffx_pkg;

  typedef enum logic [3:0] {
    STP_CONFIG    = 4'd0,
    STP_BYP_ON    = 4'd1,
    STP_CAP_ON    = 4'd2,
    STP_CAP_OFF   = 4'd3,
    STP_BYP_OFF   = 4'd4,
    STP_EN_MERGE  = 4'd5,
    STP_DETACH    = 4'd6,
    STP_OUT_MERGE = 4'd7,
    STP_RETIRE    = 4'd8,
    STP_IDLE      = 4'd15
  } step_e;

  // Returns 1 when code is the next legal step after cur for the given mode.
  function automatic logic step_legal(input step_e cur, input logic [3:0] code,
                                      input logic free_mode);
    logic ok;
    ok = 1'b0;
    if (cur == STP_IDLE || cur == STP_RETIRE) begin
      ok = (code == 4'(STP_CONFIG));
    end else if (free_mode) begin
      case (cur)
        STP_CONFIG:    ok = (code == 4'(STP_EN_MERGE));
        STP_EN_MERGE:  ok = (code == 4'(STP_OUT_MERGE));
        STP_OUT_MERGE: ok = (code == 4'(STP_RETIRE));
        default:       ok = 1'b0;
      endcase
    end else begin
      ok = (code == 4'(cur) + 4'd1);
    end
    return ok;
  endfunction

endpackage

// File: rtl/ffx_cmd_sync.sv
module ffx_cmd_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic take
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_d;

  // Synchronizer chain plus one extra flop for edge detection.
  always_comb begin
    sh_d = {sh_q[SH_W-2:0], req_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign take = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/ffx_step_seq.sv
module ffx_step_seq
  import ffx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic [3:0] code,
  input  logic       free_run_i,
  output step_e      stage,
  output logic       fr_mode,
  output logic       seq_err,
  output logic       bypass,
  output logic       capture
);
  step_e stage_d;
  logic  fr_d;
  logic  err_d;
  logic  legal;

  always_comb begin
    legal   = step_legal(stage, code, fr_mode);
    stage_d = stage;
    fr_d    = fr_mode;
    err_d   = seq_err;
    if (take) begin
      if (legal) begin
        stage_d = step_e'(code);
        if (code == 4'(STP_CONFIG)) begin
          fr_d  = free_run_i;
          err_d = 1'b0;
        end
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage   <= STP_IDLE;
      fr_mode <= 1'b0;
      seq_err <= 1'b0;
    end else begin
      stage   <= stage_d;
      fr_mode <= fr_d;
      seq_err <= err_d;
    end
  end

  // Aid path controls are decodes of the stage in gated mode.
  always_comb begin
    bypass  = !fr_mode && (stage == STP_BYP_ON || stage == STP_CAP_ON ||
                           stage == STP_CAP_OFF);
    capture = !fr_mode && (stage == STP_CAP_ON);
  end
endmodule

// File: rtl/ffx_replica_cell.sv
module ffx_replica_cell #(
  parameter int W          = 8,
  parameter bit LATCH_MODE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         fr_mode,
  input  logic         bypass,
  input  logic         capture,
  input  logic [W-1:0] orig_q,
  input  logic [W-1:0] nxt_d,
  input  logic         orig_en,
  output logic [W-1:0] rep_q
);
  logic         circ_en;
  logic         eff_en;
  logic         use_orig;
  logic         load;
  logic [W-1:0] rep_d;

  generate
    if (LATCH_MODE) begin : g_latch
      logic gate_q;
      logic gate_d;
      always_comb gate_d = orig_en;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_d;
      end
      // Storage event: gate fell from 1 to 0.
      assign circ_en = gate_q & ~orig_en;
    end else begin : g_flop
      assign circ_en = orig_en;
    end
  endgenerate

  always_comb begin
    eff_en   = fr_mode | circ_en;
    use_orig = bypass & ~eff_en;
    load     = active & (eff_en | (capture & bypass));
    rep_d    = rep_q;
    if (load) rep_d = use_orig ? orig_q : nxt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rep_q <= '0;
    else        rep_q <= rep_d;
  end
endmodule

// File: rtl/ffx_handover.sv
module ffx_handover
  import ffx_pkg::*;
#(
  parameter int W           = 8,
  parameter bit LATCH_MODE  = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_req_i,
  input  logic [3:0]   cmd_code_i,
  input  logic         free_run_i,
  input  logic [W-1:0] orig_q_i,
  input  logic [W-1:0] nxt_d_i,
  input  logic         orig_en_i,
  output logic [W-1:0] rep_q_o,
  output logic [W-1:0] out_q_o,
  output logic         retire_o,
  output logic [3:0]   stage_o,
  output logic         bypass_o,
  output logic         capture_o,
  output logic         seq_err_o
);
  logic  cmd_take;
  step_e stage;
  logic  fr_mode;
  logic  active;

  ffx_cmd_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_async (cmd_req_i),
    .take      (cmd_take)
  );

  ffx_step_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (cmd_take),
    .code       (cmd_code_i),
    .free_run_i (free_run_i),
    .stage      (stage),
    .fr_mode    (fr_mode),
    .seq_err    (seq_err_o),
    .bypass     (bypass_o),
    .capture    (capture_o)
  );

  assign active = (stage != STP_IDLE);

  ffx_replica_cell #(.W(W), .LATCH_MODE(LATCH_MODE)) cell_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .fr_mode (fr_mode),
    .bypass  (bypass_o),
    .capture (capture_o),
    .orig_q  (orig_q_i),
    .nxt_d   (nxt_d_i),
    .orig_en (orig_en_i),
    .rep_q   (rep_q_o)
  );

  assign retire_o = (stage == STP_RETIRE);
  assign stage_o  = 4'(stage);
  assign out_q_o  = retire_o ? rep_q_o : orig_q_i;
endmodule

// File: rtl/ffx_handover_chk.sv
module ffx_handover_chk #(
  parameter int W          = 8,
  parameter bit LATCH_MODE = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         take,
  input logic [3:0]   stage,
  input logic [W-1:0] orig_q,
  input logic [W-1:0] nxt_d,
  input logic         orig_en,
  input logic [W-1:0] rep_q,
  input logic         retire,
  input logic         bypass,
  input logic         capture,
  input logic         seq_err
);
  AST_STAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(stage)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (seq_err || stage == 4'd0)); // R5
  AST_CAP_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> bypass); // R6
  AST_RETIRE_AFTER_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(retire) |-> $past(stage) == 4'd7); // R11
  AST_CAPTURE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!LATCH_MODE && capture && !orig_en) |=> rep_q == $past(orig_q)); // R7
  AST_BYPASS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!LATCH_MODE && bypass && orig_en) |=> rep_q == $past(nxt_d)); // R8
endmodule

bind ffx_handover ffx_handover_chk #(.W(W), .LATCH_MODE(LATCH_MODE)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .take    (cmd_take),
  .stage   (stage_o),
  .orig_q  (orig_q_i),
  .nxt_d   (nxt_d_i),
  .orig_en (orig_en_i),
  .rep_q   (rep_q_o),
  .retire  (retire_o),
  .bypass  (bypass_o),
  .capture (capture_o),
  .seq_err (seq_err_o)
);

// File: tb/ffx_handover_tb.sv
module ffx_handover_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, cmd_req, free_run, orig_en, gate_prev, kill, scramble;
  logic [3:0]   cmd_code;
  logic [W-1:0] nxt_d, orig_a, orig_b, in_a, in_b;
  logic [W-1:0] rep_a, out_a, rep_b, out_b;
  logic [3:0]   stage_a, stage_b;
  logic         ret_a, byp_a, cap_a, err_a, ret_b, byp_b, cap_b, err_b;
  int           n_chk = 0, n_fail = 0, en_mode = 2;
  bit           track_a = 0, track_b = 0;

  assign in_a = kill ? ~orig_a : orig_a;
  assign in_b = kill ? ~orig_b : orig_b;

  ffx_handover #(.W(W), .LATCH_MODE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_req_i(cmd_req), .cmd_code_i(cmd_code),
    .free_run_i(free_run), .orig_q_i(in_a), .nxt_d_i(nxt_d), .orig_en_i(orig_en),
    .rep_q_o(rep_a), .out_q_o(out_a), .retire_o(ret_a), .stage_o(stage_a),
    .bypass_o(byp_a), .capture_o(cap_a), .seq_err_o(err_a));

  ffx_handover #(.W(W), .LATCH_MODE(1'b1)) dut_l (
    .clk(clk), .rst_n(rst_n), .cmd_req_i(cmd_req), .cmd_code_i(cmd_code),
    .free_run_i(free_run), .orig_q_i(in_b), .nxt_d_i(nxt_d), .orig_en_i(orig_en),
    .rep_q_o(rep_b), .out_q_o(out_b), .retire_o(ret_b), .stage_o(stage_b),
    .bypass_o(byp_b), .capture_o(cap_b), .seq_err_o(err_b));

  // Models of the original register: flop with enable, and falling-gate latch.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orig_a <= '0; orig_b <= '0; gate_prev <= 1'b0;
    end else begin
      if (scramble) begin
        orig_a <= orig_a ^ 8'hA5;
        orig_b <= orig_b ^ 8'h5A;
      end else begin
        if (orig_en) orig_a <= nxt_d;
        if (gate_prev && !orig_en) orig_b <= nxt_d;
      end
      gate_prev <= orig_en;
    end
  end

  // Random data and enable, changed away from the active edge.
  always @(negedge clk) begin
    nxt_d <= W'($urandom);
    case (en_mode)
      0:       orig_en <= 1'b0;
      1:       orig_en <= 1'b1;
      default: orig_en <= 1'($urandom);
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Coherency tracking of both replicas against the models.
  always @(negedge clk) begin
    if (track_a) chk("R7 replica vs original", 32'(rep_a), 32'(orig_a));
    if (track_b) chk("R12 latch replica vs latch", 32'(rep_b), 32'(orig_b));
  end

  // One command; stage must hold two falling edges and change on the third (R2).
  task automatic send(input logic [3:0] code, input logic [3:0] exp, input string tag);
    logic [3:0] old;
    @(negedge clk) cmd_code = code;
    @(negedge clk) cmd_req = 1'b1;
    old = stage_a;
    @(negedge clk);
    @(negedge clk);
    chk("R2 stage before sync delay", 32'(stage_a), 32'(old));
    @(negedge clk);
    chk(tag, 32'(stage_a), 32'(exp));
    chk(tag, 32'(stage_b), 32'(exp));
    repeat (3) @(negedge clk);
    cmd_req = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_scramble();
    @(negedge clk) scramble = 1'b1;
    @(negedge clk) scramble = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cmd_req = 1'b0; cmd_code = 4'd0; free_run = 1'b0;
    kill = 1'b0; scramble = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset stage", 32'(stage_a), 32'd15);
    chk("R1 reset retire", 32'(ret_a), 32'd0);
    chk("R1 reset error", 32'(err_a), 32'd0);
    chk("R1 reset bypass", 32'(byp_a), 32'd0);
    chk("R1 reset capture", 32'(cap_a), 32'd0);
    chk("R1 reset replica", 32'(rep_a), 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 idle replica holds", 32'(rep_a), 32'd0);

    // Illegal command from idle.
    send(4'd2, 4'd15, "R5 rejected from idle");
    chk("R5 error set", 32'(err_a), 32'd1);
    chk("R1 replica still idle", 32'(rep_b), 32'd0);

    // Transfer 1: gated mode, random enable.
    send(4'd0, 4'd0, "R3 configure");
    chk("R5 error cleared by configure", 32'(err_a), 32'd0);
    send(4'd3, 4'd0, "R5 out of order held");
    chk("R5 error set again", 32'(err_a), 32'd1);
    send(4'd1, 4'd1, "R3 bypass on");
    chk("R6 bypass at 1", 32'(byp_a), 32'd1);
    chk("R6 no capture at 1", 32'(cap_a), 32'd0);
    send(4'd2, 4'd2, "R3 capture on");
    chk("R6 capture at 2", 32'(cap_a), 32'd1);
    chk("R7 copied", 32'(rep_a), 32'(orig_a));
    track_a = 1; track_b = 1;
    send(4'd3, 4'd3, "R3 capture off");
    chk("R6 capture off", 32'(cap_a), 32'd0);
    chk("R6 bypass still on", 32'(byp_a), 32'd1);
    send(4'd4, 4'd4, "R3 bypass off");
    chk("R6 bypass off", 32'(byp_a), 32'd0);
    send(4'd5, 4'd5, "R3 enable merge");
    send(4'd6, 4'd6, "R3 detach");
    send(4'd7, 4'd7, "R3 output merge");
    chk("R10 output from original", 32'(out_a), 32'(in_a));
    chk("R10 not retired", 32'(ret_a), 32'd0);
    send(4'd8, 4'd8, "R3 retire");
    chk("R10 retired", 32'(ret_a), 32'd1);
    kill = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 output from replica", 32'(out_a), 32'(orig_a));
    chk("R12 latch output from replica", 32'(out_b), 32'(orig_b));

    // Transfer 2: enable held low for the copy, then high through bypass.
    track_a = 0; track_b = 0; kill = 1'b0;
    en_mode = 0;
    pulse_scramble();
    send(4'd0, 4'd0, "R3 configure again");
    chk("R5 error cleared", 32'(err_a), 32'd0);
    send(4'd1, 4'd1, "R3 bypass on");
    send(4'd2, 4'd2, "R3 capture on");
    chk("R7 pure copy", 32'(rep_a), 32'(orig_a));
    chk("R12 pure copy latch", 32'(rep_b), 32'(orig_b));
    track_a = 1; track_b = 1;
    en_mode = 1;
    send(4'd3, 4'd3, "R8 capture off with enable high");
    chk("R8 live value", 32'(rep_a), 32'(orig_a));
    en_mode = 2;
    send(4'd4, 4'd4, "R3 bypass off");
    send(4'd5, 4'd5, "R3 enable merge");
    send(4'd6, 4'd6, "R3 detach");
    send(4'd8, 4'd6, "R11 early retire held");
    chk("R11 not retired", 32'(ret_a), 32'd0);
    send(4'd7, 4'd7, "R3 output merge");
    send(4'd8, 4'd8, "R11 retire after merge");

    // Transfer 3: free-running mode.
    track_a = 0; track_b = 0;
    en_mode = 1; free_run = 1'b1;
    pulse_scramble();
    send(4'd0, 4'd0, "R4 configure free run");
    chk("R9 free run replica acquires", 32'(rep_a), 32'(orig_a));
    track_a = 1;
    send(4'd1, 4'd0, "R4 bypass rejected");
    chk("R4 error", 32'(err_a), 32'd1);
    send(4'd5, 4'd5, "R4 enable merge");
    chk("R6 no bypass free run", 32'(byp_a), 32'd0);
    chk("R6 no capture free run", 32'(cap_a), 32'd0);
    send(4'd6, 4'd5, "R4 detach rejected");
    send(4'd7, 4'd7, "R4 output merge");
    send(4'd8, 4'd8, "R4 retire");
    kill = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 free run output from replica", 32'(out_a), 32'(orig_a));
    chk("R9 replica follows", 32'(rep_a), 32'(orig_a));
    track_a = 0;
    summary();
    $finish;
  end
endmodule